// File: doc/BRIEF.md
# Packed Integer Dot-Product Accumulator

This block produces one element of a small matrix-multiply tile. It takes K 32-bit words that hold a row of A, K 32-bit words that hold a column of B, and a 32-bit starting value C. Each word packs one, two or four signed integer lanes. The block multiplies each A lane by the B lane in the same position and adds every product onto C. The total goes out in a 64-bit register slot.

An 8-bit format code sets the source lane width and the destination type. Only 32-bit integer destinations are computed. Any other pairing, including every floating-point type id, is flagged as an error and gives a zero result.

A new operation can be accepted on every cycle. Its result appears a fixed number of cycles later, and the pipeline never stalls.

Top module: `pkdot_acc`

## Requirements
- R1: The low nibble of `in_fmt` is the source type and the high nibble is the destination type. Type id 0 is int32, 1 is int16 and 2 is int8; ids 8 to 15 are floating-point types. The only legal codes are destination 0 with source 0, 1 or 2, which are 8'h00, 8'h01 and 8'h02. Every other code is illegal.
- R2: With source int8, each word holds four signed lanes. Lane n is bits [8n+7:8n]. Each lane is sign-extended before it is multiplied.
- R3: With source int16, each word holds two signed lanes. Lane 0 is bits [15:0] and lane 1 is bits [31:16]. Each lane is sign-extended before it is multiplied.
- R4: With source int32, each word is one lane. Word w of A and of B is `in_a`/`in_b` bits [32w+31:32w].
- R5: The result is C plus the sum of all lane products over all K words. It wraps modulo 2^32.
- R6: For a legal operation, `out_data[31:0]` is the result and `out_data[63:32]` is all ones.
- R7: For an illegal operation, `out_err` is 1 and `out_data` is all zero, while `out_valid` is still raised.
- R8: `out_valid` rises exactly 6 cycles after the cycle in which `in_valid` is high. Operations on consecutive cycles each give their own result on consecutive cycles.
- R9: While `rst_n` is low, `out_valid`, `out_err` and `out_data` are zero. Operations in flight at reset are discarded.
- R10: When `out_valid` is 0, `out_err` is 0 and `out_data` is zero, whatever the format or data that was presented with `in_valid` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation presented this cycle |
| in_fmt | input | 8 | Format code: destination type in [7:4], source type in [3:0] |
| in_a | input | 32*K | Row of A, word 0 in the low bits |
| in_b | input | 32*K | Column of B, word 0 in the low bits |
| in_c | input | 32 | Accumulator start value |
| out_valid | output | 1 | Result valid |
| out_err | output | 1 | Unsupported format for this result |
| out_data | output | 64 | Result slot: ones above a 32-bit sum, or zero on error |

## Verification
The checker assumes that `in_valid` is a clean level sampled at each rising edge. It also assumes that reset is the only event that clears operations in flight. On that basis it models the valid path as a plain delay and relates the output slot only to `out_valid` and `out_err`. The bench drives every input on the falling edge and holds it steady through the next rising edge. It keeps `rst_n` low for whole cycles. The illegal codes are presented with nonzero operands, and the idle cycles with a floating-point code, so that a leak of data or of the error flag would reach the outputs.

// File: rtl/pdp_pkg.sv
package pdp_pkg;
   localparam int unsigned WORD_W = 32;
   localparam int unsigned SLOT_W = 64;

   localparam logic [3:0] TYPE_I32 = 4'd0;
   localparam logic [3:0] TYPE_I16 = 4'd1;
   localparam logic [3:0] TYPE_I8  = 4'd2;

   typedef enum logic [1:0] {
      MODE_W32 = 2'd0,
      MODE_W16 = 2'd1,
      MODE_W8  = 2'd2
   } lane_mode_t;
endpackage

// File: rtl/pdp_fmt_decode.sv
module pdp_fmt_decode
   import pdp_pkg::*;
(
   input  logic [7:0]  fmt,
   output lane_mode_t  mode,
   output logic        illegal
);
   logic [3:0] src_t;
   logic [3:0] dst_t;

   assign src_t = fmt[3:0];
   assign dst_t = fmt[7:4];

   always_comb begin
      mode    = MODE_W32;
      illegal = 1'b1;
      if (dst_t == TYPE_I32) begin
         unique case (src_t)
            TYPE_I32: begin mode = MODE_W32; illegal = 1'b0; end
            TYPE_I16: begin mode = MODE_W16; illegal = 1'b0; end
            TYPE_I8:  begin mode = MODE_W8;  illegal = 1'b0; end
            default:  begin mode = MODE_W32; illegal = 1'b1; end
         endcase
      end
   end
endmodule

// File: rtl/pdp_lane_sum.sv
module pdp_lane_sum #(
   parameter int unsigned LANE_W = 8
) (
   input  logic [31:0] a,
   input  logic [31:0] b,
   output logic [31:0] sum
);
   localparam int unsigned LANES = 32 / LANE_W;

   if ((32 % LANE_W) != 0 || LANE_W == 0) begin : g_bad_lane
      $error("pdp_lane_sum: LANE_W must divide 32");
   end

   always_comb begin
      sum = '0;
      for (int l = 0; l < LANES; l++) begin
         sum = sum + 32'($signed(a[l*LANE_W +: LANE_W]))
                   * 32'($signed(b[l*LANE_W +: LANE_W]));
      end
   end
endmodule

// File: rtl/pdp_word_dot.sv
module pdp_word_dot
   import pdp_pkg::*;
#(
   parameter int unsigned K = 4
) (
   input  logic [K*32-1:0] a,
   input  logic [K*32-1:0] b,
   input  logic [31:0]     c,
   input  lane_mode_t      mode,
   output logic [31:0]     acc
);
   localparam int unsigned NVAR = 3;

   logic [31:0] part [K][NVAR];
   logic [31:0] pick [K];

   for (genvar w = 0; w < K; w++) begin : g_word
      for (genvar v = 0; v < NVAR; v++) begin : g_var
         pdp_lane_sum #(.LANE_W(32 >> v)) u_lane (
            .a   (a[w*32 +: 32]),
            .b   (b[w*32 +: 32]),
            .sum (part[w][v])
         );
      end
      always_comb begin
         unique case (mode)
            MODE_W16: pick[w] = part[w][1];
            MODE_W8:  pick[w] = part[w][2];
            default:  pick[w] = part[w][0];
         endcase
      end
   end

   always_comb begin
      acc = c;
      for (int w = 0; w < K; w++) acc = acc + pick[w];
   end
endmodule

// File: rtl/pdp_pipe.sv
module pdp_pipe #(
   parameter int unsigned W     = 8,
   parameter int unsigned DEPTH = 6
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (DEPTH == 0) begin : g_wire
      assign q = d;
   end else begin : g_regs
      logic [W-1:0] stage [DEPTH];
      for (genvar s = 0; s < DEPTH; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      stage[s] <= '0;
            else if (s == 0) stage[s] <= d;
            else             stage[s] <= stage[s-1];
         end
      end
      assign q = stage[DEPTH-1];
   end
endmodule

// File: rtl/pkdot_acc.sv
module pkdot_acc
   import pdp_pkg::*;
#(
   parameter int unsigned K        = 4,
   parameter int unsigned BASE_LAT = 2,
   parameter int unsigned COMP_LAT = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            in_valid,
   input  logic [7:0]      in_fmt,
   input  logic [K*32-1:0] in_a,
   input  logic [K*32-1:0] in_b,
   input  logic [31:0]     in_c,
   output logic            out_valid,
   output logic            out_err,
   output logic [63:0]     out_data
);
   localparam int unsigned LAT   = BASE_LAT + COMP_LAT;
   localparam int unsigned PAY_W = 2 + WORD_W;

   if (K < 1) begin : g_bad_k
      $error("pkdot_acc: K must be at least 1");
   end
   if (LAT < 2) begin : g_bad_lat
      $error("pkdot_acc: total latency must be at least 2");
   end

   lane_mode_t  mode;
   logic        illegal;
   logic [31:0] acc;
   logic [PAY_W-1:0] pay_in, pay_out;
   logic        p_valid, p_err;
   logic [31:0] p_sum;

   pdp_fmt_decode u_dec (
      .fmt     (in_fmt),
      .mode    (mode),
      .illegal (illegal)
   );

   pdp_word_dot #(.K(K)) u_dot (
      .a    (in_a),
      .b    (in_b),
      .c    (in_c),
      .mode (mode),
      .acc  (acc)
   );

   always_comb begin
      pay_in = '0;
      if (in_valid) begin
         pay_in = {1'b1, illegal, (illegal ? 32'h0 : acc)};
      end
   end

   pdp_pipe #(.W(PAY_W), .DEPTH(LAT)) u_pipe (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pay_in),
      .q     (pay_out)
   );

   assign {p_valid, p_err, p_sum} = pay_out;

   assign out_valid = p_valid;
   assign out_err   = p_valid & p_err;
   assign out_data  = (p_valid && !p_err) ? {32'hFFFF_FFFF, p_sum} : 64'h0;
endmodule

// File: rtl/pkdot_acc_chk.sv
module pkdot_acc_chk #(
   parameter int unsigned LAT = 6
) (
   input logic        clk,
   input logic        rst_n,
   input logic        in_valid,
   input logic        out_valid,
   input logic        out_err,
   input logic [63:0] out_data
);
   logic [LAT-1:0] vshadow;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) vshadow <= '0;
      else        vshadow <= {vshadow[LAT-2:0], in_valid};
   end

   assert_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid == vshadow[LAT-1]);

   assert_upper_ones_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_err) |-> (out_data[63:32] == 32'hFFFF_FFFF));

   assert_err_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_err) |-> (out_data == 64'h0));

   assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> (!out_err && out_data == 64'h0));

   assert_reset_clear_R9: assert property (@(posedge clk)
      !rst_n |=> !out_valid);
endmodule

bind pkdot_acc pkdot_acc_chk #(.LAT(LAT)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .out_valid (out_valid),
   .out_err   (out_err),
   .out_data  (out_data)
);

// File: tb/pkdot_acc_test.sv
module pkdot_acc_test;
   localparam int KW = 2;
   localparam int N  = 12;

   typedef struct packed {
      logic [7:0]  fmt;
      logic [63:0] a;
      logic [63:0] b;
      logic [31:0] c;
      logic        err;
      logic [63:0] res;
      logic [7:0]  req;
   } vec_t;

   // a and b are {word1, word0}
   localparam vec_t VECS [N] = '{
      '{8'h00, 64'h00000003_00000005, 64'h00000007_00000002, 32'h0000000A, 1'b0, 64'hFFFFFFFF_00000029, 8'd4}, // R4
      '{8'h00, 64'h00000000_FFFFFFFF, 64'h00000009_00000005, 32'h00000000, 1'b0, 64'hFFFFFFFF_FFFFFFFB, 8'd4}, // R4
      '{8'h01, 64'h00010001_00020003, 64'h00100010_0004FFFF, 32'h00000064, 1'b0, 64'hFFFFFFFF_00000089, 8'd3}, // R3
      '{8'h02, 64'h80000000_01020304, 64'h02000000_01010101, 32'h00000000, 1'b0, 64'hFFFFFFFF_FFFFFF0A, 8'd2}, // R2
      '{8'h00, 64'h00000000_40000000, 64'h00000000_00000004, 32'h00000007, 1'b0, 64'hFFFFFFFF_00000007, 8'd5}, // R5
      '{8'h02, 64'h00000000_FF7F0180, 64'h00000000_FFFF7F80, 32'hFFFFFFFF, 1'b0, 64'hFFFFFFFF_00004000, 8'd2}, // R2
      '{8'h01, 64'h00000000_00008000, 64'h00000000_00008000, 32'h00000000, 1'b0, 64'hFFFFFFFF_40000000, 8'd3}, // R3
      '{8'h11, 64'h00000003_00000005, 64'h00000007_00000002, 32'h0000000A, 1'b1, 64'h0, 8'd7},               // R7
      '{8'h08, 64'h00000003_00000005, 64'h00000007_00000002, 32'h0000000A, 1'b1, 64'h0, 8'd1},               // R1
      '{8'h03, 64'h00000003_00000005, 64'h00000007_00000002, 32'h0000000A, 1'b1, 64'h0, 8'd1},               // R1
      '{8'h20, 64'h00000003_00000005, 64'h00000007_00000002, 32'h0000000A, 1'b1, 64'h0, 8'd1},               // R1
      '{8'h12, 64'h01010101_01010101, 64'h01010101_01010101, 32'h00000001, 1'b1, 64'h0, 8'd7}                // R7
   };

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            in_valid = 1'b0;
   logic [7:0]      in_fmt = '0;
   logic [KW*32-1:0] in_a = '0;
   logic [KW*32-1:0] in_b = '0;
   logic [31:0]     in_c = '0;
   logic            out_valid;
   logic            out_err;
   logic [63:0]     out_data;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   pkdot_acc #(.K(KW)) uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_fmt    (in_fmt),
      .in_a      (in_a),
      .in_b      (in_b),
      .in_c      (in_c),
      .out_valid (out_valid),
      .out_err   (out_err),
      .out_data  (out_data)
   );

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic drive(input int i);
      in_valid = 1'b1;
      in_fmt   = VECS[i].fmt;
      in_a     = VECS[i].a;
      in_b     = VECS[i].b;
      in_c     = VECS[i].c;
   endtask

   initial begin
      #(20 * 100000);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      // R9: reset state
      repeat (3) @(negedge clk);
      check("R9 valid", {63'h0, out_valid}, 64'h0);
      check("R9 err",   {63'h0, out_err},   64'h0);
      check("R9 data",  out_data,           64'h0);
      rst_n = 1'b1;

      // Vector table streamed back to back (R8), results 6 cycles later
      for (int j = 0; j < N + 6; j++) begin
         @(negedge clk);
         if (j >= 6) begin
            check($sformatf("R8 valid vec%0d", j - 6), {63'h0, out_valid}, 64'h1);
            check($sformatf("R%0d err vec%0d", VECS[j-6].req, j - 6), {63'h0, out_err}, {63'h0, VECS[j-6].err});
            check($sformatf("R%0d data vec%0d", VECS[j-6].req, j - 6), out_data, VECS[j-6].res);
         end else begin
            check("R10 early idle", {63'h0, out_valid}, 64'h0);
         end
         if (j < N) drive(j);
         else in_valid = 1'b0;
      end

      // R10: floating-point format with in_valid low leaves outputs quiet
      in_valid = 1'b0;
      in_fmt   = 8'h99;
      in_a     = '1;
      in_b     = '1;
      in_c     = 32'h1234_5678;
      for (int d = 0; d < 8; d++) begin
         @(negedge clk);
         check("R10 idle valid", {63'h0, out_valid}, 64'h0);
         check("R10 idle err",   {63'h0, out_err},   64'h0);
         check("R10 idle data",  out_data,           64'h0);
      end

      // R8: a lone operation appears exactly on the sixth cycle
      @(negedge clk);
      drive(0);
      for (int d = 1; d <= 6; d++) begin
         @(negedge clk);
         if (d == 1) in_valid = 1'b0;
         check($sformatf("R8 lone op cycle %0d", d), {63'h0, out_valid}, (d == 6) ? 64'h1 : 64'h0);
      end
      check("R6 lone op data", out_data, 64'hFFFFFFFF_00000029);

      // R9: reset discards an operation in flight
      @(negedge clk);
      drive(2);
      @(negedge clk);
      in_valid = 1'b0;
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      check("R9 reset valid", {63'h0, out_valid}, 64'h0);
      check("R9 reset data",  out_data,           64'h0);
      rst_n = 1'b1;
      for (int d = 0; d < 7; d++) begin
         @(negedge clk);
         check("R9 flushed", {63'h0, out_valid}, 64'h0);
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule